// File: doc/BRIEF.md
# Synchronous Serial Slave Receiver

This block captures characters arriving on a serial data line that is clocked by an external master. The external clock and the data line are brought into the system clock domain through short synchronizer chains, and each rising edge of the external clock samples one data bit, least significant bit first. Once a complete character (eight bits, or nine when the wide-character mode is selected) has been gathered, it is written into a two-entry receive queue. The ninth bit travels with its byte, so the ninth-bit output always belongs to the character at the head of the queue.

Software sees a data-available flag, which may also raise an interrupt, reads the head character on the data port, and pops it with a read strobe. When a character completes while the queue is already full, that character is thrown away and a sticky overrun flag is raised. Reception then stops until the receive enable or the port enable is dropped. Dropping the port enable puts the whole receiver back into its reset state. In this slave role, reception runs continuously while enabled, and the single-character request input has no effect.

Top module: `sync_slave_rx`

## Requirements
- R1: After reset, rxDone, overrun and rxIrq are low.
- R2: With nineBitEn low, eight bits sampled on consecutive rising edges of serClk form one character, with the first bit as bit 0. The character appears on rdData with rxDone high and rdNinth low.
- R3: With nineBitEn high, nine bits form one character. Bits 0 to 7 appear on rdData and bit 8 appears on rdNinth.
- R4: The queue holds two characters and returns them in arrival order. A one-cycle rdStrobe pulse removes the head character, and rxDone falls once the queue is empty.
- R5: rxIrq is high exactly when rxDone and rxIntEn are both high.
- R6: A character that completes while two characters are queued is discarded and sets overrun. The queued characters are unchanged.
- R7: While overrun is set, no new character is received, and reading the queue does not clear overrun.
- R8: Lowering contRxEn clears overrun and keeps the queued characters.
- R9: Lowering portEn empties the queue, clears overrun and discards a partly received character.
- R10: singleRxReq has no effect. Reception depends only on portEn and contRxEn.
- R11: Characters sent back to back with no gap between them are all received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portEn | input | 1 | Port enable; low holds the receiver in reset |
| contRxEn | input | 1 | Continuous receive enable |
| singleRxReq | input | 1 | Single-character request, ignored in slave role |
| nineBitEn | input | 1 | Selects nine-bit characters |
| rxIntEn | input | 1 | Receive interrupt enable |
| serClk | input | 1 | External serial clock |
| serData | input | 1 | Serial data line |
| rdStrobe | input | 1 | Pops the head character |
| rdData | output | 8 | Low eight bits of the head character |
| rdNinth | output | 1 | Ninth bit of the head character |
| rxDone | output | 1 | Queue holds at least one character |
| overrun | output | 1 | Sticky overrun error |
| rxIrq | output | 1 | Receive interrupt |

## Verification
The hardest situation to reach is the overrun state with a partly filled queue, where the block must refuse new characters until the receive enable is dropped. The stimulus sends three characters without reading, which creates the overrun. It then reads one character to open a free slot and sends another complete character while the flag is still set. It then empties the queue to show that the late character never arrived, and repeats the sequence around a drop of contRxEn to show that the queued data survives.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  typedef struct packed {
    logic shiftEn;   // sample one bit into the shift register
    logic wordDone;  // final bit of a character sampled this cycle
    logic push;      // write the completed character into the queue
    logic pop;       // remove head character
    logic clearAll;  // port disabled: flush everything
  } rxStrobes_t;
endpackage

// File: rtl/sync_rx_ctrl.sv
module sync_rx_ctrl
  import sync_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DATA_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             portEn,
  input  logic             contRxEn,
  input  logic             nineBitEn,
  input  logic             serClk,
  input  logic             serData,
  input  logic             rdStrobe,
  input  logic             fifoFull,
  output rxStrobes_t       strobes,
  output logic [CNT_W-1:0] bitIdx,
  output logic             sampledBit,
  output logic             overrun
);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(DATA_W);

  logic [SYNC_STAGES:0]   clkPipe;
  logic [SYNC_STAGES-1:0] dataPipe;
  logic                   clkRise;
  logic                   active;
  logic [CNT_W-1:0]       lastIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPipe  <= '0;
      dataPipe <= '0;
    end else begin
      clkPipe  <= {clkPipe[SYNC_STAGES-1:0], serClk};
      dataPipe <= {dataPipe[SYNC_STAGES-2:0], serData};
    end
  end

  assign clkRise    = clkPipe[SYNC_STAGES-1] & ~clkPipe[SYNC_STAGES];
  assign sampledBit = dataPipe[SYNC_STAGES-1];
  assign active     = portEn & contRxEn & ~overrun;
  assign lastIdx    = nineBitEn ? LAST_WIDE : LAST_NARROW;

  always_comb begin
    strobes          = '0;
    strobes.clearAll = ~portEn;
    strobes.shiftEn  = active & clkRise;
    strobes.wordDone = strobes.shiftEn & (bitIdx == lastIdx);
    strobes.push     = strobes.wordDone & ~fifoFull;
    strobes.pop      = rdStrobe & portEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 bitIdx <= '0;
    else if (!active)          bitIdx <= '0;
    else if (strobes.wordDone) bitIdx <= '0;
    else if (strobes.shiftEn)  bitIdx <= bitIdx + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              overrun <= 1'b0;
    else if (!portEn || !contRxEn)          overrun <= 1'b0;
    else if (strobes.wordDone && fifoFull)  overrun <= 1'b1;
  end
endmodule

// File: rtl/sync_rx_dpath.sv
module sync_rx_dpath
  import sync_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2,
  localparam int CNT_W = $clog2(DATA_W + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxStrobes_t       strobes,
  input  logic [CNT_W-1:0] bitIdx,
  input  logic             sampledBit,
  input  logic             nineBitEn,
  output logic [DATA_W:0]  headWord,
  output logic             fifoFull,
  output logic             fifoEmpty
);
  logic [DATA_W:0]  shiftReg;
  logic [DATA_W:0]  nextWord;
  logic [DATA_W:0]  pushWord;
  logic [DATA_W:0]  mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [OCC_W-1:0] occupancy;
  logic             doPop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    nextWord         = shiftReg;
    nextWord[bitIdx] = sampledBit;
    pushWord         = {nextWord[DATA_W] & nineBitEn, nextWord[DATA_W-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   shiftReg <= '0;
    else if (strobes.clearAll || strobes.wordDone) shiftReg <= '0;
    else if (strobes.shiftEn)                    shiftReg[bitIdx] <= sampledBit;
  end

  assign fifoFull  = (occupancy == OCC_W'(DEPTH));
  assign fifoEmpty = (occupancy == '0);
  assign doPop     = strobes.pop & ~fifoEmpty;
  assign headWord  = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      occupancy <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strobes.clearAll) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      occupancy <= '0;
    end else begin
      if (strobes.push) begin
        mem[wrPtr] <= pushWord;
        wrPtr      <= bump(wrPtr);
      end
      if (doPop) rdPtr <= bump(rdPtr);
      case ({strobes.push, doPop})
        2'b10:   occupancy <= occupancy + 1'b1;
        2'b01:   occupancy <= occupancy - 1'b1;
        default: occupancy <= occupancy;
      endcase
    end
  end
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx
  import sync_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portEn,
  input  logic              contRxEn,
  input  logic              singleRxReq,
  input  logic              nineBitEn,
  input  logic              rxIntEn,
  input  logic              serClk,
  input  logic              serData,
  input  logic              rdStrobe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdNinth,
  output logic              rxDone,
  output logic              overrun,
  output logic              rxIrq
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  rxStrobes_t       strobes;
  logic [CNT_W-1:0] bitIdx;
  logic             sampledBit;
  logic             fifoFull, fifoEmpty;
  logic [DATA_W:0]  headWord;
  logic             unusedSingleReq;

  // slave role: reception is always continuous, the single request is ignored
  assign unusedSingleReq = singleRxReq;

  sync_rx_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .portEn(portEn), .contRxEn(contRxEn),
    .nineBitEn(nineBitEn), .serClk(serClk), .serData(serData),
    .rdStrobe(rdStrobe), .fifoFull(fifoFull), .strobes(strobes),
    .bitIdx(bitIdx), .sampledBit(sampledBit), .overrun(overrun)
  );

  sync_rx_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .bitIdx(bitIdx),
    .sampledBit(sampledBit), .nineBitEn(nineBitEn), .headWord(headWord),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty)
  );

  assign rdData  = headWord[DATA_W-1:0];
  assign rdNinth = headWord[DATA_W];
  assign rxDone  = ~fifoEmpty;
  assign rxIrq   = rxDone & rxIntEn;
endmodule

// File: rtl/sync_slave_rx_chk.sv
module sync_slave_rx_chk (
  input logic clk,
  input logic rstN,
  input logic portEn,
  input logic contRxEn,
  input logic rxDone,
  input logic overrun,
  input logic rxIrq
);
  assert_irq_needs_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> rxDone);

  assert_ovr_only_when_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> rxDone);

  assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && portEn && contRxEn) |=> overrun);

  assert_ovr_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    !contRxEn |=> !overrun);

  assert_port_flush_R9: assert property (@(posedge clk) disable iff (!rstN)
    !portEn |=> (!rxDone && !overrun));
endmodule

bind sync_slave_rx sync_slave_rx_chk u_chk (
  .clk(clk), .rstN(rstN), .portEn(portEn), .contRxEn(contRxEn),
  .rxDone(rxDone), .overrun(overrun), .rxIrq(rxIrq)
);

// File: tb/sync_slave_rx_tb.sv
`timescale 1ns/1ps
module sync_slave_rx_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic portEn = 1'b0, contRxEn = 1'b0, singleRxReq = 1'b0, nineBitEn = 1'b0;
  logic rxIntEn = 1'b0, serClk = 1'b0, serData = 1'b0, rdStrobe = 1'b0;
  logic [7:0] rdData;
  logic rdNinth, rxDone, overrun, rxIrq;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  sync_slave_rx u_dut (
    .clk(clk), .rstN(rstN), .portEn(portEn), .contRxEn(contRxEn),
    .singleRxReq(singleRxReq), .nineBitEn(nineBitEn), .rxIntEn(rxIntEn),
    .serClk(serClk), .serData(serData), .rdStrobe(rdStrobe),
    .rdData(rdData), .rdNinth(rdNinth), .rxDone(rxDone),
    .overrun(overrun), .rxIrq(rxIrq)
  );

  // {nine-bit mode, 9-bit pattern}; narrow entries send only the low 8 bits
  localparam logic [9:0] VEC [6] = '{
    {1'b0, 9'h0A5}, {1'b0, 9'h03C}, {1'b1, 9'h1FF},
    {1'b1, 9'h080}, {1'b1, 9'h17E}, {1'b0, 9'h1C3}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk) serData = b;
    repeat (3) @(negedge clk);
    serClk = 1'b1;
    repeat (6) @(negedge clk);
    serClk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendWord(input logic [8:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) sendBit(w[i]);
  endtask

  task automatic popOne();
    @(negedge clk) rdStrobe = 1'b1;
    @(negedge clk) rdStrobe = 1'b0;
  endtask

  task automatic pulseLow(input bit port);
    @(negedge clk);
    if (port) portEn = 1'b0; else contRxEn = 1'b0;
    repeat (2) @(negedge clk);
    portEn = 1'b1; contRxEn = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rxDone", rxDone, 0);
    check("R1 overrun", overrun, 0);
    check("R1 rxIrq", rxIrq, 0);
    portEn = 1'b1; contRxEn = 1'b1;

    // R2 R3 R5: table of characters
    for (int i = 0; i < 6; i++) begin
      nineBitEn = VEC[i][9];
      rxIntEn   = i[0];
      sendWord(VEC[i][8:0], VEC[i][9] ? 9 : 8);
      check("R2 rxDone", rxDone, 1);
      check("R2 R3 rdData", rdData, VEC[i][7:0]);
      check("R3 rdNinth", rdNinth, VEC[i][9] & VEC[i][8]);
      check("R5 rxIrq", rxIrq, i % 2);
      popOne();
      check("R4 empty after pop", rxDone, 0);
      check("R5 irq low when empty", rxIrq, 0);
    end
    nineBitEn = 1'b0; rxIntEn = 1'b0;

    // R4 R11: back-to-back characters, arrival order
    sendWord(9'h011, 8);
    sendWord(9'h022, 8);
    check("R11 first kept", rdData, 8'h11);
    popOne();
    check("R4 second head", rdData, 8'h22);
    check("R4 still done", rxDone, 1);
    popOne();
    check("R4 empty", rxDone, 0);

    // R6: third character while full
    sendWord(9'h033, 8);
    sendWord(9'h044, 8);
    check("R6 no overrun at two", overrun, 0);
    sendWord(9'h055, 8);
    check("R6 overrun set", overrun, 1);
    check("R6 head kept", rdData, 8'h33);
    // R7: free a slot, overrun must persist and block reception
    popOne();
    check("R7 read keeps overrun", overrun, 1);
    check("R6 second kept", rdData, 8'h44);
    sendWord(9'h077, 8);
    check("R7 still overrun", overrun, 1);
    check("R7 head unchanged", rdData, 8'h44);
    // R8: drop continuous enable
    pulseLow(1'b0);
    check("R8 overrun cleared", overrun, 0);
    check("R8 queue kept", rxDone, 1);
    check("R8 head kept", rdData, 8'h44);
    sendWord(9'h088, 8);
    popOne();
    check("R7 blocked word absent", rdData, 8'h88);
    popOne();
    check("R7 R8 empty", rxDone, 0);

    // R9: port disable flushes queue, overrun and partial character
    sendWord(9'h099, 8);
    sendWord(9'h0AA, 8);
    sendWord(9'h0BB, 8);
    check("R9 overrun before", overrun, 1);
    sendWord(9'h007, 3);
    pulseLow(1'b1);
    check("R9 queue flushed", rxDone, 0);
    check("R9 overrun flushed", overrun, 0);
    sendWord(9'h0A5, 8);
    check("R9 fresh char", rdData, 8'hA5);
    check("R9 only one char", rxDone, 1);
    popOne();
    check("R9 empty", rxDone, 0);

    // R10: single request ignored
    singleRxReq = 1'b1;
    sendWord(9'h05A, 4);
    singleRxReq = 1'b0;
    sendWord(9'h005, 4);
    check("R10 received with toggling request", rdData, 8'h5A);
    popOne();
    @(negedge clk) contRxEn = 1'b0; singleRxReq = 1'b1;
    sendWord(9'h0C3, 8);
    check("R10 request does not enable rx", rxDone, 0);
    singleRxReq = 1'b0; contRxEn = 1'b1;

    summary();
    $finish;
  end
endmodule